// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block sits inside a synchronous DRAM controller. It holds the programmable mode word and uses it to produce the column address of every beat of a read or write burst. A load command with the bank-select pair at zero checks the mode field on the address bus. If the field is legal, the block stores it. If it carries reserved or non-standard values, the block rejects it and keeps the old contents. A load aimed at the extended register is recognised and ignored.

When a burst starts, the block latches the starting column and then issues one column per clock. A fixed-length burst of 2, 4 or 8 beats stays inside an aligned block of that size, chosen by the column bits above the burst's low bits. Inside the block the order is either sequential with wrap, or interleaved, where the beat count is XORed into the low bits. A full-page burst counts sequentially through the whole row and wraps from the last column to column 0. It runs until a terminate input ends it. When write single-location mode is set, every write burst is one beat long, while reads keep the programmed length. The column width is a parameter: 8 for a x32 part, 9 for a x16 part.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, valid_o, done_o and err_o are 0 and cas_lat_o is 2. The stored mode is sequential with burst length 1, full page off and write single-location off.
- R2: A load (load_i=1) with ba_i=00 and a legal field takes effect for bursts started after it. The field layout on mode_i is: [2:0] length code (000=1, 001=2, 010=4, 011=8, 111=full page), [3] burst type (0 sequential, 1 interleaved), [6:4] CAS latency, [8:7] operating mode, [9] write single-location.
- R3: A load with ba_i other than 00 (10 selects the extended register) changes nothing and raises no error.
- R4: A load with ba_i=00 is rejected if any of these holds: a length code of 100, 101 or 110; code 111 with interleaved type; a CAS code of 000 or 1xx; a nonzero operating mode. A rejected load keeps all stored fields and drives err_o high for exactly the cycle after the load edge.
- R5: A start_i sampled at a clock edge puts the starting column on col_o with valid_o=1 in the next cycle. Each following cycle carries one more beat. done_o is 1 together with the last beat of a fixed-length burst, and valid_o is 0 in the cycle after that beat.
- R6: In sequential order, beat k of a burst of length L (2, 4 or 8) is (c & ~(L-1)) | ((c + k) mod L), where c is the starting column.
- R7: In interleaved order, beat k is (c & ~(L-1)) | ((c ^ k) & (L-1)).
- R8: A full-page burst issues (c + k) mod 2^COL_W, wraps past the last column of the row and never raises done_o on its own.
- R9: A term_i sampled during an active burst (without start_i) gives valid_o=0 and done_o=1 in the next cycle, and no further beats.
- R10: A start_i sampled during an active burst abandons it without a done pulse and issues the new starting column in the next cycle.
- R11: With write single-location set, a burst started with rw_i=1 is one beat long (done_o with its only beat). A burst with rw_i=0 uses the programmed length.
- R12: cas_lat_o presents the stored CAS latency (1, 2 or 3) from the cycle after the accepting load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Mode register load command |
| ba_i | input | 2 | Bank-select pair for the load |
| mode_i | input | 10 | Mode field from the address bus |
| start_i | input | 1 | Start a burst |
| rw_i | input | 1 | 1 = write burst, 0 = read burst |
| col_i | input | COL_W | Starting column |
| term_i | input | 1 | Terminate the active burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | col_o carries a beat |
| done_o | output | 1 | Burst finished (last beat or termination) |
| err_o | output | 1 | Rejected load, one-cycle pulse |
| cas_lat_o | output | 2 | Stored CAS latency |

## Verification
Every result here has one register stage. The first beat, err_o and a new cas_lat_o appear in the cycle after the edge that samples start_i or load_i. Beat k comes k cycles later, and the idle or done state after a termination shows one cycle after term_i. The bench drives inputs on the falling edge and samples on the next falling edge, so each output is read exactly in the cycle these latencies name. The bench sweeps every starting column for each length and burst type. The expected columns come from the masking arithmetic in the requirements.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int MODE_W = 10;

  typedef struct packed {
    logic       wr_single;
    logic       ilv;
    logic       full;
    logic [1:0] len_log;
    logic [1:0] cas;
  } mode_t;

  localparam mode_t MODE_RST = '{wr_single: 1'b0, ilv: 1'b0, full: 1'b0,
                                 len_log: 2'd0, cas: 2'd2};
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [1:0]        ba_i,
  input  logic [MODE_W-1:0] mode_i,
  output mode_t             mode_o,
  output logic              err_o
);
  logic [2:0] len_code;
  logic [2:0] cas_code;
  logic       field_ok;
  logic       std_sel;

  assign len_code = mode_i[2:0];
  assign cas_code = mode_i[6:4];
  assign std_sel  = load_i && (ba_i == 2'b00);

  always_comb begin
    field_ok = 1'b1;
    if (!(len_code <= 3'd3 || (len_code == 3'd7 && !mode_i[3]))) field_ok = 1'b0;
    if (cas_code == 3'd0 || cas_code[2]) field_ok = 1'b0;
    if (mode_i[8:7] != 2'b00) field_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= MODE_RST;
      err_o  <= 1'b0;
    end else begin
      err_o <= std_sel && !field_ok;
      if (std_sel && field_ok) begin
        mode_o.wr_single <= mode_i[9];
        mode_o.ilv       <= mode_i[3];
        mode_o.full      <= (len_code == 3'd7);
        mode_o.len_log   <= len_code[1:0];
        mode_o.cas       <= cas_code[1:0];
      end
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;

  always_comb begin
    low   = ilv_i ? (start_col_i ^ beat_i) : (start_col_i + beat_i);
    col_o = (start_col_i & ~mask_i) | (low & mask_i);
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_t            mode_i,
  input  logic             start_i,
  input  logic             rw_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             done_o,
  output logic             active_o,
  output logic [COL_W-1:0] mask_o
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] ONE      = COL_W'(1);

  logic             single;
  logic             new_full;
  logic [COL_W-1:0] new_mask;
  logic [COL_W-1:0] start_col_q;
  logic [COL_W-1:0] beat_q;
  logic             ilv_q;
  logic             full_q;
  logic [COL_W-1:0] gen_col;
  logic             last_beat;

  assign single   = mode_i.wr_single && rw_i;
  assign new_full = mode_i.full && !single;

  always_comb begin
    if (new_full)    new_mask = ALL_ONES;
    else if (single) new_mask = '0;
    else             new_mask = (ONE << mode_i.len_log) - ONE;
  end

  burst_addr_gen #(.COL_W(COL_W)) gen_i (
    .start_col_i(start_col_q),
    .beat_i     (beat_q),
    .mask_i     (mask_o),
    .ilv_i      (ilv_q),
    .col_o      (gen_col)
  );

  assign last_beat = !full_q && (beat_q == mask_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_col_q <= '0;
      beat_q      <= '0;
      ilv_q       <= 1'b0;
      full_q      <= 1'b0;
      mask_o      <= '0;
      col_o       <= '0;
      valid_o     <= 1'b0;
      done_o      <= 1'b0;
      active_o    <= 1'b0;
    end else if (start_i) begin
      start_col_q <= col_i;
      beat_q      <= ONE;
      ilv_q       <= mode_i.ilv && !new_full;
      full_q      <= new_full;
      mask_o      <= new_mask;
      col_o       <= col_i;
      valid_o     <= 1'b1;
      done_o      <= !new_full && (new_mask == '0);
      active_o    <= new_full || (new_mask != '0);
    end else if (active_o && term_i) begin
      active_o <= 1'b0;
      valid_o  <= 1'b0;
      done_o   <= 1'b1;
    end else if (active_o) begin
      col_o    <= gen_col;
      valid_o  <= 1'b1;
      done_o   <= last_beat;
      active_o <= !last_beat;
      beat_q   <= beat_q + ONE;
    end else begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [1:0]        ba_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              start_i,
  input  logic              rw_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        cas_lat_o
);
  mode_t            mode_q;
  logic             busy_w;
  logic [COL_W-1:0] blk_mask_w;

  burst_mode_reg mreg_i (
    .clk   (clk),
    .rst   (rst),
    .load_i(load_i),
    .ba_i  (ba_i),
    .mode_i(mode_i),
    .mode_o(mode_q),
    .err_o (err_o)
  );

  burst_ctrl #(.COL_W(COL_W)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_q),
    .start_i (start_i),
    .rw_i    (rw_i),
    .col_i   (col_i),
    .term_i  (term_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .done_o  (done_o),
    .active_o(busy_w),
    .mask_o  (blk_mask_w)
  );

  assign cas_lat_o = mode_q.cas;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load_i,
  input logic [1:0]       ba_i,
  input logic             start_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             done_o,
  input logic             err_o,
  input logic [1:0]       cas_lat_o,
  input logic             active,
  input logic [COL_W-1:0] mask
);
  AST_EXT_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (load_i && ba_i != 2'b00) |=> ($stable(cas_lat_o) && !err_o)); // R3

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $stable(cas_lat_o)); // R4

  AST_ERR_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ($past(load_i) && $past(ba_i) == 2'b00)); // R4

  AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && !$past(start_i) && !$past(term_i))
      |-> (((col_o ^ $past(col_o)) & ~mask) == '0)); // R6

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> !valid_o); // R5

  AST_TERM_STOPS: assert property (@(posedge clk) disable iff (rst)
    (active && term_i && !start_i) |=> (done_o && !valid_o)); // R9

  AST_START_ISSUES: assert property (@(posedge clk) disable iff (rst)
    start_i |=> valid_o); // R10
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .load_i   (load_i),
  .ba_i     (ba_i),
  .start_i  (start_i),
  .term_i   (term_i),
  .col_o    (col_o),
  .valid_o  (valid_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .cas_lat_o(cas_lat_o),
  .active   (busy_w),
  .mask     (blk_mask_w)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  localparam int COL_W = 8;
  localparam int ROW   = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             load_i = 1'b0;
  logic [1:0]       ba_i = 2'b00;
  logic [9:0]       mode_i = '0;
  logic             start_i = 1'b0;
  logic             rw_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic             term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             done_o;
  logic             err_o;
  logic [1:0]       cas_lat_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .load_i(load_i), .ba_i(ba_i), .mode_i(mode_i),
    .start_i(start_i), .rw_i(rw_i), .col_i(col_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .done_o(done_o), .err_o(err_o),
    .cas_lat_o(cas_lat_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input int code, input int bt, input int cas,
                                    input int op, input int wb);
    return {wb[0], op[1:0], cas[2:0], bt[0], code[2:0]};
  endfunction

  function automatic int exp_col(input int c, input int k, input int len, input int ilv);
    int m;
    m = len - 1;
    if (ilv != 0) return (c & ~m) | ((c ^ k) & m);
    return (c & ~m) | ((c + k) & m);
  endfunction

  task automatic do_load(input logic [1:0] ba, input logic [9:0] f,
                         input int exp_err, input int exp_cas, input string req);
    load_i = 1'b1; ba_i = ba; mode_i = f;
    @(negedge clk);
    load_i = 1'b0;
    check({req, " err"}, int'(err_o), exp_err);
    check({req, " cas"}, int'(cas_lat_o), exp_cas);
    @(negedge clk);
    check({req, " err one cycle"}, int'(err_o), 0);
  endtask

  task automatic run_burst(input int c, input logic rw, input int len,
                           input int ilv, input string req);
    start_i = 1'b1; col_i = c[COL_W-1:0]; rw_i = rw;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < len; k++) begin
      check({req, " valid"}, int'(valid_o), 1);
      check({req, " col"}, int'(col_o), exp_col(c, k, len, ilv));
      check({req, " done"}, int'(done_o), (k == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    check({req, " idle after"}, int'(valid_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(valid_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 err", int'(err_o), 0);
    check("R1 cas", int'(cas_lat_o), 2);
    run_burst(37, 1'b0, 1, 0, "R1 len1");

    // R12 CAS latency values
    do_load(2'b00, mk(0, 0, 3, 0, 0), 0, 3, "R12 cas3");
    do_load(2'b00, mk(0, 0, 1, 0, 0), 0, 1, "R12 cas1");

    // R6 R7 R2 sweep over all starting columns, lengths and types
    for (int bt = 0; bt < 2; bt++) begin
      for (int lg = 0; lg < 4; lg++) begin
        do_load(2'b00, mk(lg, bt, 2, 0, 0), 0, 2, "R2 load");
        for (int c = 0; c < ROW; c++)
          run_burst(c, 1'b0, 1 << lg, bt, (bt != 0) ? "R7 ilv" : "R6 seq");
      end
    end

    // R3 extended and other bank selects ignored (mode stays ilv len 8, cas 2)
    do_load(2'b10, mk(1, 0, 3, 0, 0), 0, 2, "R3 ext");
    do_load(2'b01, mk(0, 0, 1, 0, 0), 0, 2, "R3 ba01");
    run_burst(13, 1'b0, 8, 1, "R3 kept");

    // R4 rejected loads keep contents
    do_load(2'b00, mk(4, 0, 3, 0, 0), 1, 2, "R4 len100");
    do_load(2'b00, mk(7, 1, 3, 0, 0), 1, 2, "R4 ilv full");
    do_load(2'b00, mk(1, 0, 0, 0, 0), 1, 2, "R4 cas0");
    do_load(2'b00, mk(1, 0, 4, 0, 0), 1, 2, "R4 cas4");
    do_load(2'b00, mk(1, 0, 3, 1, 0), 1, 2, "R4 opmode");
    run_burst(13, 1'b0, 8, 1, "R4 kept");

    // R8 full page wraps past row end
    do_load(2'b00, mk(7, 0, 2, 0, 0), 0, 2, "R8 load");
    start_i = 1'b1; col_i = 8'd250; rw_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < ROW + 4; k++) begin
      check("R8 valid", int'(valid_o), 1);
      check("R8 col", int'(col_o), (250 + k) % ROW);
      check("R8 no done", int'(done_o), 0);
      if (k < ROW + 3) @(negedge clk);
    end
    // R9 terminate
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check("R9 valid", int'(valid_o), 0);
    check("R9 done", int'(done_o), 1);
    @(negedge clk);
    check("R9 stays idle", int'(valid_o), 0);
    check("R9 done once", int'(done_o), 0);

    // R10 restart during active burst
    do_load(2'b00, mk(3, 0, 2, 0, 0), 0, 2, "R10 load");
    start_i = 1'b1; col_i = 8'd5; rw_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R10 first col", int'(col_o), exp_col(5, k, 8, 0));
      @(negedge clk);
    end
    run_burst(8'h40, 1'b0, 8, 0, "R10 restart");

    // R11 write single-location
    do_load(2'b00, mk(2, 0, 2, 0, 1), 0, 2, "R11 load");
    run_burst(22, 1'b1, 1, 0, "R11 write");
    run_burst(22, 1'b0, 4, 0, "R11 read");

    // R5 back-to-back bursts
    do_load(2'b00, mk(1, 0, 2, 0, 0), 0, 2, "R5 load");
    run_burst(9, 1'b0, 2, 0, "R5 a");
    run_burst(200, 1'b0, 2, 0, "R5 b");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule